// File: doc/BRIEF.md
# NAND Ready/Busy Timeout Monitor

This block watches the ready/busy line of a NAND flash device and raises an error when the device stays busy for longer than a programmed number of clock cycles. The line is active-low: 0 means busy. It passes through a two-flop synchronizer, and the monitor acts on the synchronized busy level and on its rising edge. Each entry into busy loads a 20-bit working counter from a setting register. The counter then steps down once per clock. If it reaches zero while the device is still busy, a sticky error flag is set.

Software reaches the block through a small word-wide register port that has three locations. Location 0 holds the timeout setting. Location 1 is a read-only word that packs the last flash status byte together with the live count. Location 2 holds the error flag and its interrupt enable. The status byte is taken from an 8-bit input on a one-cycle strobe, which the surrounding controller raises when a status-read transfer completes. The interrupt output is high while the error flag and the enable are both set.

Top module: `nand_rb_watchdog`

## Requirements
- R1: Location 0 (`reg_sel`=0) holds a 20-bit timeout setting in bits 19:0, which resets to 0. Bits 31:20 always read 0, and writes to them have no effect.
- R2: When the setting is 0, a busy period of any length leaves the count at 0 and never sets the error flag.
- R3: `rb_n` is active-low and is synchronized by two flops. On the third clock edge after `rb_n` falls, the count is loaded with the setting. On each later edge while busy it decreases by 1, down to a floor of 0.
- R4: The error flag is set on the edge at which the count steps from 1 to 0 while busy. With setting T, this is edge 3+T after `rb_n` falls.
- R5: If the device returns to ready before expiry, the count stops and holds. Because of the synchronizer, it takes two further decrements first. No error is raised, and the next busy entry reloads the count.
- R6: The error flag is location 2 bit 0. It stays set until a write puts 0 in that bit. Writing 1 to it has no effect.
- R7: The interrupt enable is location 2 bit 1. `irq` is high exactly when the error flag and the enable are both 1.
- R8: Location 1 reads the status byte in bits 31:24, zeros in bits 23:20 and the live count in bits 19:0. It reads all zeros after reset.
- R9: The status byte changes only on a clock edge where `stat_strobe` is 1. It then takes the value of `stat_byte`.
- R10: Once the count has expired, staying busy does not set the error flag again after software has cleared it. Only a new busy entry restarts the timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rb_n | input | 1 | Flash ready/busy line, 0 = busy, asynchronous |
| stat_strobe | input | 1 | One-cycle pulse marking a completed status read |
| stat_byte | input | 8 | Status byte returned by the flash |
| reg_sel | input | 2 | Register location select |
| reg_we | input | 1 | Write enable for the selected location |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected location (combinational) |
| irq | output | 1 | Timeout interrupt request |

## Verification
The bench sweeps the setting from 1 to 10. After every clock edge of a long busy period it checks both the count and the error flag. An off-by-one in the synchronizer delay or the load timing would therefore show up as a count shifted by one, or as an error one cycle early or late.

It also covers three further cases:
- A zero setting: a design that loads 0 and then decrements would wrap the count and fire.
- Release before expiry: a design that kept counting after ready would drift, and one that cleared the count on ready would lose the held value.
- Continued busy after the flag is cleared: a design that compared the count with zero on every cycle would set the flag again.

Writes of 1 to the flag, and writes to the unused upper setting bits, must change nothing that can be read back.

// File: rtl/nand_rb_watchdog.sv
module nand_rb_watchdog #(
  parameter int CNT_W  = 20,
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rb_n,
  input  logic              stat_strobe,
  input  logic [STAT_W-1:0] stat_byte,
  input  logic [1:0]        reg_sel,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq
);
  localparam int PAD_W = 32 - STAT_W - CNT_W;
  localparam int SET_PAD_W = 32 - CNT_W;

  logic              rb_s1, rb_s2, busy_q;
  logic              busy, busy_rise;
  logic [CNT_W-1:0]  tmo, cnt;
  logic [STAT_W-1:0] stat_q;
  logic              err, ie;
  logic              expire;

  assign busy      = ~rb_s2;
  assign busy_rise = busy & ~busy_q;
  assign expire    = busy & ~busy_rise & (cnt == CNT_W'(1));
  assign irq       = err & ie;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rb_s1  <= 1'b1;
      rb_s2  <= 1'b1;
      busy_q <= 1'b0;
    end else begin
      rb_s1  <= rb_n;
      rb_s2  <= rb_s1;
      busy_q <= busy;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      cnt <= '0;
    else if (busy_rise)
      cnt <= tmo;
    else if (busy && cnt != '0)
      cnt <= cnt - CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tmo <= '0;
      ie  <= 1'b0;
      err <= 1'b0;
    end else begin
      if (reg_we && reg_sel == 2'd0) tmo <= reg_wdata[CNT_W-1:0];
      if (reg_we && reg_sel == 2'd2) ie <= reg_wdata[1];
      if (expire)
        err <= 1'b1;
      else if (reg_we && reg_sel == 2'd2 && !reg_wdata[0])
        err <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            stat_q <= '0;
    else if (stat_strobe)  stat_q <= stat_byte;

  always_comb
    case (reg_sel)
      2'd0:    reg_rdata = {{SET_PAD_W{1'b0}}, tmo};
      2'd1:    reg_rdata = {stat_q, {PAD_W{1'b0}}, cnt};
      2'd2:    reg_rdata = {30'b0, ie, err};
      default: reg_rdata = '0;
    endcase

  // R3: a busy entry loads the setting, then the count steps down
  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_rise |=> cnt == $past(tmo));
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !busy_rise && cnt != '0) |=> cnt == $past(cnt) - CNT_W'(1));
  // R2: a zero setting keeps the count at zero
  p_zero_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_rise && tmo == '0) |=> cnt == '0);
  // R5: while ready, the count holds
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(cnt));
  // R4: the flag only rises from an expiry while busy
  p_err_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> ($past(busy) && $past(cnt) == CNT_W'(1) && cnt == '0));
  // R7: no interrupt without the flag
  p_irq_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> err);
  // R9: the status byte moves only on a strobe
  p_stat_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_strobe |=> $stable(stat_q));
endmodule

// File: tb/nand_rb_watchdog_test.sv
module nand_rb_watchdog_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q = CLK_PERIOD / 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rb_n = 1'b1;
  logic        stat_strobe = 1'b0;
  logic [7:0]  stat_byte = 8'h00;
  logic [1:0]  reg_sel = 2'd1;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  nand_rb_watchdog uut (
    .clk(clk), .rst_n(rst_n), .rb_n(rb_n), .stat_strobe(stat_strobe),
    .stat_byte(stat_byte), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_sel = sel; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_sel = 2'd1;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] d);
    reg_sel = sel;
    #1;
    d = reg_rdata;
    reg_sel = 2'd1;
    #1;
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #Q;
  endtask

  initial begin
    logic [31:0] v;
    int exp_cnt;
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int exp_cnt;
    #(CLK_PERIOD*3);
    @(negedge clk); rst_n = 1'b1;
    #Q;
    rd(2'd0, v); chk("R1 reset setting", v, 32'h0);
    rd(2'd1, v); chk("R8 reset readback", v, 32'h0);
    rd(2'd2, v); chk("R6 reset control", v, 32'h0);
    chk("R7 reset irq", {31'b0, irq}, 32'h0);

    wr(2'd0, 32'hFFFF_FFFF); #Q;
    rd(2'd0, v); chk("R1 upper bits read zero", v, 32'h000F_FFFF);
    wr(2'd0, 32'hABC1_2345); #Q;
    rd(2'd0, v); chk("R1 setting value", v, 32'h0001_2345);

    @(negedge clk); stat_byte = 8'hA5; stat_strobe = 1'b1;
    @(negedge clk); stat_strobe = 1'b0; stat_byte = 8'h3C;
    #Q; rd(2'd1, v); chk("R8 status in 31:24", v, 32'hA500_0000);
    edges(3);
    rd(2'd1, v); chk("R9 status held without strobe", v, 32'hA500_0000);

    // Sweep settings: count and flag after every edge of a long busy period
    for (int t = 1; t <= 10; t++) begin
      wr(2'd0, t);
      wr(2'd2, 32'h2);
      @(negedge clk); rb_n = 1'b0;
      for (int n = 1; n <= t + 6; n++) begin
        edges(1);
        if (n >= 3) begin
          exp_cnt = (n - 3 >= t) ? 0 : t - (n - 3);
          rd(2'd1, v);
          chk("R3 live count", v, {8'hA5, 4'h0, 20'(exp_cnt)});
          chk("R4 flag timing", {31'b0, irq}, {31'b0, (n >= 3 + t)});
        end
      end
      wr(2'd2, 32'h3); #Q;
      rd(2'd2, v); chk("R6 write 1 keeps flag", v, 32'h3);
      wr(2'd2, 32'h1); #Q;
      chk("R7 irq masked", {31'b0, irq}, 32'h0);
      rd(2'd2, v); chk("R7 flag kept when masked", v, 32'h1);
      wr(2'd2, 32'h2); #Q;
      rd(2'd2, v); chk("R6 write 0 clears flag", v, 32'h2);
      edges(8);
      chk("R10 no re-flag while still busy", {31'b0, irq}, 32'h0);
      @(negedge clk); rb_n = 1'b1;
      edges(4);
    end

    // Zero setting
    wr(2'd0, 32'h0);
    @(negedge clk); rb_n = 1'b0;
    edges(25);
    rd(2'd1, v); chk("R2 zero setting count", v, 32'hA500_0000);
    chk("R2 zero setting no irq", {31'b0, irq}, 32'h0);
    @(negedge clk); rb_n = 1'b1;
    edges(4);

    // Early release
    wr(2'd0, 32'd20);
    @(negedge clk); rb_n = 1'b0;
    edges(6);
    rd(2'd1, v); chk("R3 count after 6 edges", v, {8'hA5, 4'h0, 20'd17});
    rb_n = 1'b1;
    edges(12);
    rd(2'd1, v); chk("R5 count holds after ready", v, {8'hA5, 4'h0, 20'd15});
    chk("R5 no irq after early ready", {31'b0, irq}, 32'h0);
    @(negedge clk); rb_n = 1'b0;
    edges(3);
    rd(2'd1, v); chk("R5 reload on new busy entry", v, {8'hA5, 4'h0, 20'd20});
    @(negedge clk); rb_n = 1'b1;
    edges(4);

    @(negedge clk); stat_byte = 8'h5E; stat_strobe = 1'b1;
    @(negedge clk); stat_strobe = 1'b0;
    #Q; rd(2'd1, v); chk("R9 new strobe captures byte", v[31:24], 32'h5E);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule